// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns a 32-bit address seen on a PCI bus into a 34-bit system DMA address. Four programmable windows each supply a base, a mask and a translated base. They arrive as inputs from a register file elsewhere in the chip. An incoming address is compared against every window. The lowest-numbered enabled window that matches decides how the address is translated. If no enabled window matches, the address passes through unchanged.

A matching window works in one of two modes. In direct mode, the high address bits are swapped for bits of the translated base, with the mask setting how many bits pass through. In scatter-gather mode, the block first forms the address of a 64-bit page-table entry. It reads that entry through a simple request/response memory port and builds the final address from the entry's page number and the low 13 bits of the bus address.

Requests use a valid/ready handshake. Only one translation is in flight at a time. The result is offered on a response channel and held there until it is taken.

Top module: `pci_win_xlate`

## Requirements
- R1: When several enabled windows match, the window with the smallest index (0 first, 3 last) decides the translation.
- R2: Window w matches when bus address bits 31:20 equal window base bits 31:20 at every position where window mask bits 31:20 are 0. Mask bits 19:0 and base bits 19:2 never affect matching.
- R3: Bit 0 of a window base enables the window. A window with this bit at 0 is skipped even if its address range matches, and the search goes on to the next index.
- R4: In direct mode (base bit 1 = 0), the pass mask P is mask bits 31:20 together with all of bits 19:0. The result is (translated base AND NOT P) OR (bus address AND P), over 34 bits. No memory read is issued.
- R5: In scatter-gather mode (base bit 1 = 1), exactly one read is issued. Its address is (translated base with bits 9:0 and the mask bits 31:20 shifted right by 10 cleared) OR ((bus address AND (mask bits 31:20 plus bits 19:13)) shifted right by 10).
- R6: In scatter-gather mode, the result is bits 33:0 of ((entry with bit 0 cleared) shifted left by 12) OR bus address bits 12:0.
- R7: With no enabled matching window, the result is the bus address zero-extended to 34 bits, and no memory read is issued.
- R8: req_ready is low from the cycle after a request is accepted until the cycle after its response is accepted. No second request is taken meanwhile.
- R9: Once rsp_valid rises, it and rsp_addr stay unchanged until rsp_ready is seen high. rsp_valid falls in the following cycle.
- R10: After synchronous reset, req_ready is 1 and rsp_valid and mem_req_valid are 0.
- R11: While mem_req_valid is high and mem_req_ready is low, mem_req_addr holds its value and mem_req_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | PCI bus address to translate |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 34 | Translated DMA address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Address of the page-table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Page-table entry |
| win_base | input | 4x32 | Per-window base; bit 0 enable, bit 1 scatter-gather |
| win_mask | input | 4x32 | Per-window mask; bits 31:20 used |
| win_tbase | input | 4x34 | Per-window translated base |

## Verification
The assertions assume the memory side is well behaved. It returns exactly one mem_rsp_valid pulse for each accepted read, and only after that read is accepted. The window inputs only need to be steady in the cycle a request is accepted, because the block captures everything it needs at that point. The bench memory model answers only an accepted read, and with varied stall and latency. The bench changes window settings only between translations, when no request is in flight. rsp_ready is kept low for several cycles so that the hold behaviour is exercised.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    localparam int BUS_W  = 32;
    localparam int DMA_W  = 34;
    localparam int ENT_W  = 64;
    localparam int NWIN   = 4;
    localparam int CMP_LO = 20;
    localparam int OFF_W  = 13;
    localparam int PG_SH  = 12;
    localparam int PTE_SH = 10;
    localparam int EN_BIT = 0;
    localparam int SG_BIT = 1;

    localparam logic [BUS_W-1:0] HI_MASK = {{(BUS_W-CMP_LO){1'b1}}, {CMP_LO{1'b0}}};
    localparam logic [BUS_W-1:0] LO_MASK = ~HI_MASK;
    localparam logic [BUS_W-1:0] PG_MASK = {{(BUS_W-CMP_LO){1'b0}}, {(CMP_LO-OFF_W){1'b1}}, {OFF_W{1'b0}}};
    localparam logic [DMA_W-1:0] TBL_LO  = {{(DMA_W-PTE_SH){1'b0}}, {PTE_SH{1'b1}}};

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_MREQ  = 2'd1,
        XS_MWAIT = 2'd2,
        XS_RESP  = 2'd3
    } xs_state_t;

    typedef struct packed {
        logic             use_sg;
        logic [DMA_W-1:0] direct_addr;
        logic [DMA_W-1:0] ent_addr;
        logic [OFF_W-1:0] offset;
    } xlate_plan_t;

    function automatic logic [DMA_W-1:0] widen(input logic [BUS_W-1:0] v);
        return {{(DMA_W-BUS_W){1'b0}}, v};
    endfunction

    function automatic logic [DMA_W-1:0] direct_map(input logic [BUS_W-1:0] bus,
                                                    input logic [BUS_W-1:0] mask,
                                                    input logic [DMA_W-1:0] tbase);
        logic [DMA_W-1:0] pass;
        pass = widen((mask & HI_MASK) | LO_MASK);
        return (tbase & ~pass) | (widen(bus) & pass);
    endfunction

    function automatic logic [DMA_W-1:0] entry_addr(input logic [BUS_W-1:0] bus,
                                                    input logic [BUS_W-1:0] mask,
                                                    input logic [DMA_W-1:0] tbase);
        logic [DMA_W-1:0] clr;
        logic [DMA_W-1:0] pick;
        clr  = (widen(mask & HI_MASK) >> PTE_SH) | TBL_LO;
        pick = widen(bus & ((mask & HI_MASK) | PG_MASK)) >> PTE_SH;
        return (tbase & ~clr) | pick;
    endfunction

    function automatic logic [DMA_W-1:0] sg_build(input logic [ENT_W-1:0] ent,
                                                  input logic [OFF_W-1:0] off);
        logic [ENT_W-1:0] shifted;
        shifted = (ent & ~ENT_W'(1)) << PG_SH;
        return shifted[DMA_W-1:0] | {{(DMA_W-OFF_W){1'b0}}, off};
    endfunction
endpackage

// File: rtl/pwt_win_cmp.sv
module pwt_win_cmp
    import pwt_pkg::*;
(
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] base,
    input  logic [BUS_W-1:0] mask,
    output logic             hit
);
    logic [BUS_W-1:0] care;
    logic             same;

    assign care = ~mask & HI_MASK;
    assign same = ((bus_addr & care) == (base & care));
    assign hit  = base[EN_BIT] & same;
endmodule

// File: rtl/pwt_prio_pick.sv
module pwt_prio_pick #(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NUM-1:0]   hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pwt_xlate_calc.sv
module pwt_xlate_calc
    import pwt_pkg::*;
#(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic [BUS_W-1:0]          bus_addr,
    input  logic                      found,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM-1:0][BUS_W-1:0] win_base,
    input  logic [NUM-1:0][BUS_W-1:0] win_mask,
    input  logic [NUM-1:0][DMA_W-1:0] win_tbase,
    output xlate_plan_t               plan
);
    logic [BUS_W-1:0] sel_base;
    logic [BUS_W-1:0] sel_mask;
    logic [DMA_W-1:0] sel_tbase;

    always_comb begin
        sel_base  = '0;
        sel_mask  = '0;
        sel_tbase = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_base  = win_base[i];
                sel_mask  = win_mask[i];
                sel_tbase = win_tbase[i];
            end
        end
    end

    always_comb begin
        plan.use_sg      = found & sel_base[SG_BIT];
        plan.direct_addr = found ? direct_map(bus_addr, sel_mask, sel_tbase) : widen(bus_addr);
        plan.ent_addr    = entry_addr(bus_addr, sel_mask, sel_tbase);
        plan.offset      = bus_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  xlate_plan_t      plan,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [DMA_W-1:0] rsp_addr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [DMA_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data
);
    xs_state_t        state_q;
    logic [DMA_W-1:0] res_q;
    logic [DMA_W-1:0] ent_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            res_q   <= '0;
            ent_q   <= '0;
            off_q   <= '0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (req_valid) begin
                        if (plan.use_sg) begin
                            ent_q   <= plan.ent_addr;
                            off_q   <= plan.offset;
                            state_q <= XS_MREQ;
                        end else begin
                            res_q   <= plan.direct_addr;
                            state_q <= XS_RESP;
                        end
                    end
                end
                XS_MREQ: begin
                    if (mem_req_ready) begin
                        state_q <= XS_MWAIT;
                    end
                end
                XS_MWAIT: begin
                    if (mem_rsp_valid) begin
                        res_q   <= sg_build(mem_rsp_data, off_q);
                        state_q <= XS_RESP;
                    end
                end
                XS_RESP: begin
                    if (rsp_ready) begin
                        state_q <= XS_IDLE;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == XS_IDLE);
    assign rsp_valid     = (state_q == XS_RESP);
    assign rsp_addr      = res_q;
    assign mem_req_valid = (state_q == XS_MREQ);
    assign mem_req_addr  = ent_q;
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
    import pwt_pkg::*;
#(
    parameter int NUM_WIN = NWIN
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [BUS_W-1:0]              req_addr,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic [DMA_W-1:0]              rsp_addr,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [DMA_W-1:0]              mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [ENT_W-1:0]              mem_rsp_data,
    input  logic [NUM_WIN-1:0][BUS_W-1:0] win_base,
    input  logic [NUM_WIN-1:0][BUS_W-1:0] win_mask,
    input  logic [NUM_WIN-1:0][DMA_W-1:0] win_tbase
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0] hit_v;
    logic               found;
    logic [IDX_W-1:0]   idx;
    xlate_plan_t        plan;

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            pwt_win_cmp u_cmp (
                .bus_addr (req_addr),
                .base     (win_base[g]),
                .mask     (win_mask[g]),
                .hit      (hit_v[g])
            );
        end
    endgenerate

    pwt_prio_pick #(.NUM(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .hits  (hit_v),
        .found (found),
        .idx   (idx)
    );

    pwt_xlate_calc #(.NUM(NUM_WIN), .IDX_W(IDX_W)) u_calc (
        .bus_addr  (req_addr),
        .found     (found),
        .idx       (idx),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_tbase (win_tbase),
        .plan      (plan)
    );

    pwt_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .plan          (plan),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_addr      (rsp_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );
endmodule

// File: rtl/pwt_xlate_chk.sv
module pwt_xlate_chk
    import pwt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [DMA_W-1:0] rsp_addr,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [DMA_W-1:0] mem_req_addr
);
    // R8
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    busy_while_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R5
    read_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (!req_ready && !rsp_valid));

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)));

    // R9
    rsp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> !rsp_valid);

    // R11
    mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid));
endmodule

bind pci_win_xlate pwt_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pci_win_xlate_tb.sv
module pci_win_xlate_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b0;
    logic [33:0]      rsp_addr;
    logic             mem_req_valid;
    logic             mem_req_ready = 1'b0;
    logic [33:0]      mem_req_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [63:0]      mem_rsp_data = '0;
    logic [3:0][31:0] wb = '0;
    logic [3:0][31:0] wm = '0;
    logic [3:0][33:0] tb = '0;

    pci_win_xlate u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .win_base(wb), .win_mask(wm), .win_tbase(tb)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_reads = 0;
    int mem_stall = 0;
    int mem_lat = 0;
    logic [33:0] seen_ea = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ent_of(input logic [33:0] a);
        return {a[29:0], a ^ 34'h0_5A5A_5A5B};
    endfunction

    // Behavioural reference: first enabled window in index order decides.
    function automatic void model(input logic [31:0] bus, output logic [33:0] dma,
                                  output bit sg, output logic [33:0] ea);
        logic [31:0] care;
        logic [33:0] pass;
        logic [33:0] clr;
        logic [63:0] ent;
        logic [63:0] tmp;
        bit          taken;
        dma = {2'b00, bus};
        sg = 0;
        ea = '0;
        taken = 0;
        for (int w = 0; w < 4; w++) begin
            care = ~wm[w] & 32'hFFF0_0000;
            if (!taken && wb[w][0] && ((bus & care) == (wb[w] & care))) begin
                taken = 1;
                if (wb[w][1]) begin
                    sg  = 1;
                    clr = ({2'b00, wm[w] & 32'hFFF0_0000} >> 10) | 34'h3FF;
                    ea  = (tb[w] & ~clr) | ({2'b00, bus & ((wm[w] & 32'hFFF0_0000) | 32'h000F_E000)} >> 10);
                    ent = ent_of(ea);
                    tmp = ((ent & ~64'h1) << 12) | {51'h0, bus[12:0]};
                    dma = tmp[33:0];
                end else begin
                    pass = {2'b00, (wm[w] & 32'hFFF0_0000) | 32'h000F_FFFF};
                    dma  = (tb[w] & ~pass) | ({2'b00, bus} & pass);
                end
            end
        end
    endfunction

    // Memory model: answers only accepted reads.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (mem_stall) @(negedge clk);
                mem_req_ready = 1'b1;
                seen_ea = mem_req_addr;
                n_reads++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_data  = ent_of(seen_ea);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Per-clock comparison of handshake behaviour.
    logic        p_rv = 0, p_rr = 0, p_mv = 0, p_mr = 0;
    logic [33:0] p_ra = '0, p_ma = '0;
    always @(posedge clk) begin
        p_rv <= rsp_valid; p_rr <= rsp_ready; p_ra <= rsp_addr;
        p_mv <= mem_req_valid; p_mr <= mem_req_ready; p_ma <= mem_req_addr;
    end
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid) chk(!req_ready, "R8 ready low while response pending", 64'(req_ready), 64'h0);
            if (p_rv && !p_rr) chk(rsp_valid && rsp_addr == p_ra, "R9 response held", 64'(rsp_addr), 64'(p_ra));
            if (p_mv && !p_mr) chk(mem_req_valid && mem_req_addr == p_ma, "R11 read request held", 64'(mem_req_addr), 64'(p_ma));
        end
    end

    task automatic run(input logic [31:0] bus, input int hold, input int stall, input int lat, input string tag);
        logic [33:0] exp;
        logic [33:0] ea;
        bit          sg;
        int          reads0;
        int          t;
        model(bus, exp, sg, ea);
        mem_stall = stall;
        mem_lat = lat;
        reads0 = n_reads;
        @(negedge clk);
        chk(req_ready === 1'b1, "R8 idle accepts", 64'(req_ready), 64'h1);
        req_valid = 1'b1;
        req_addr = bus;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = 32'h0;
        chk(req_ready === 1'b0, "R8 busy after accept", 64'(req_ready), 64'h0);
        t = 0;
        while (!rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        repeat (hold) @(negedge clk);
        chk(rsp_valid && rsp_addr === exp, tag, 64'(rsp_addr), 64'(exp));
        if (sg) begin
            chk(n_reads == reads0 + 1, "R5 one entry read", 64'(n_reads - reads0), 64'h1);
            chk(seen_ea === ea, "R5 entry address", 64'(seen_ea), 64'(ea));
        end else begin
            chk(n_reads == reads0, "R4 R7 no memory read", 64'(n_reads - reads0), 64'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9 release after accept", {62'h0, rsp_valid, req_ready}, 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R10 reset state",
            {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

        run(32'hDEAD_BEEF, 0, 0, 0, "R7 no window passthrough");

        wb[0] = 32'h4000_0001; wm[0] = 32'h0030_0000; tb[0] = 34'h2_ABC0_0000;
        run(32'h4012_3456, 2, 0, 0, "R4 direct map");
        run(32'h403F_FFFF, 0, 0, 0, "R4 direct map top of window");
        run(32'h4070_0000, 0, 0, 0, "R2 compared bit differs");
        wm[0] = 32'h0030_0ABC; wb[0] = 32'h4000_FFFD;
        run(32'h4021_0000, 1, 0, 0, "R2 low mask and base bits ignored");

        wb[1] = 32'h4000_0001; wm[1] = 32'h00F0_0000; tb[1] = 34'h1_0000_0000;
        run(32'h4010_0000, 0, 0, 0, "R1 lowest index wins");
        run(32'h40A0_0000, 0, 0, 0, "R1 second window only");
        wb[0] = 32'h4000_0000;
        run(32'h4010_0000, 0, 0, 0, "R3 disabled window skipped");

        wb[2] = 32'h8000_0003; wm[2] = 32'h0010_0000; tb[2] = 34'h1_2345_6000;
        run(32'h8012_3ABC, 0, 0, 0, "R6 scatter gather result");
        run(32'h801F_FFFF, 3, 3, 2, "R6 scatter gather with stalls");
        run(32'h8000_1FFF, 1, 1, 4, "R6 scatter gather low offset");
        wb[3] = 32'h8000_0001; wm[3] = 32'h0000_0000; tb[3] = 34'h3_0000_0000;
        run(32'h8005_0000, 0, 0, 0, "R1 scatter gather window beats later");
        wb[2] = 32'h8000_0002;
        run(32'h8005_0000, 0, 0, 0, "R3 disabled gather window skipped");
        run(32'hC000_0000, 0, 0, 0, "R7 no enabled match");

        wb[3] = 32'hFFF0_0001;
        run(32'hFFFF_FFFF, 0, 0, 0, "R4 34-bit result");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule